// File: doc/BRIEF.md
# Isolation Link Edge-to-Pulse Encoder

This block is the sending half of a multi-channel digital isolation link. Every channel samples an asynchronous logic input, brings it into the clock domain, and turns each change of level into a one-clock strobe. A strobe on the set line means the level is now high, and a strobe on the clear line means it is now low. A receiver that acts on these strobes can rebuild each waveform on the far side of the barrier.

A pulse is only sent on a change, so a static input would give the receiver nothing to confirm the level by. To cover that, each channel has its own quiet-time timer. When the timer runs out, the channel sends its present level again as a refresh strobe. With a 200 MHz clock and the default count of 200 cycles, this gives a refresh rate of 1 Mbps. The receiver can also treat a long gap in strobes as a dead sender.

A power-good input gates every strobe. While it is low, nothing leaves the block. When it returns, every channel sends its level at once. Inputs are meant to have pulses no shorter than 100 ns and a data rate of no more than 10 Mbps.

Top module: `isolink_tx_encoder`

## Requirements
- R1: A rising input on a channel gives a one-cycle strobe on that channel's `set_pulse`. The strobe is visible in the cycle after the third rising clock edge following the input change: two synchroniser flops, then the output register.
- R2: A falling input on a channel gives a one-cycle strobe on that channel's `clr_pulse`, with the same latency as R1.
- R3: A channel never drives `set_pulse` and `clr_pulse` in the same cycle. No strobe is wider than one cycle, even when the input toggles every cycle.
- R4: While a powered channel's input stays static, that channel repeats its level every `REFRESH_CYCLES` cycles (default 200): `set_pulse` when the level is 1, `clr_pulse` when it is 0.
- R5: An edge strobe restarts the refresh timer of its own channel, so the next refresh comes `REFRESH_CYCLES` cycles after the edge strobe.
- R6: When an edge strobe and a timer expiry fall in the same cycle, the channel emits exactly one strobe, carrying the new level, and the timer restarts from that strobe.
- R7: Each channel's edges and refresh timer act only on that channel. The other channels keep their own refresh schedule.
- R8: After any clock edge at which `pwr_ok` is sampled low, no strobe appears. Input edges seen while power is low are dropped and are not sent later.
- R9: In the cycle after the first clock edge that samples `pwr_ok` high again, every channel emits a refresh of its current synchronised level. The refresh schedule of every channel restarts from there.
- R10: While `rst_n` is low, both strobe outputs are all zero.
- R11: A 100 ns (20-cycle) input pulse yields a set strobe and then a clear strobe, exactly 20 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (200 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Sending-side supply good; low suppresses all strobes |
| din | input | N_CH | Asynchronous logic input, one bit per channel |
| set_pulse | output | N_CH | One-cycle strobe: the channel's level is high |
| clr_pulse | output | N_CH | One-cycle strobe: the channel's level is low |

## Verification
Two functions can claim the same channel in the same cycle: the edge detector and the expiry of that channel's refresh timer. The bench provokes this by timing an input change so that its strobe lands exactly on the cycle where the timer would expire. The expected result is a single clear strobe with no stale set strobe beside it, and a refresh schedule that restarts from that strobe. A second overlap comes when power returns in the same cycle that inputs have already moved. The bench checks that the strobes sent then carry the new levels.

// File: rtl/isolink_pkg.sv
`timescale 1ns/1ps
package isolink_pkg;
  // Pair of strobes produced by one channel in one cycle
  typedef struct packed {
    logic set;
    logic clr;
  } strobe_t;
endpackage

// File: rtl/isolink_sync.sv
`timescale 1ns/1ps
module isolink_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/isolink_refresh_timer.sv
`timescale 1ns/1ps
module isolink_refresh_timer #(
  parameter int REFRESH_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic restart,
  output logic expire
);
  localparam int CNT_W = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(REFRESH_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign expire = (cnt_q == TERM);

  // While power is bad the count is parked at its end value,
  // so the first good cycle fires a refresh at once.
  always_comb begin
    cnt_d = cnt_q;
    if (!pwr_ok)      cnt_d = TERM;
    else if (restart) cnt_d = '0;
    else if (!expire) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= TERM;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/isolink_chan.sv
`timescale 1ns/1ps
module isolink_chan
  import isolink_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int REFRESH_CYCLES = 200
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwr_ok,
  input  logic    din,
  output strobe_t strobe
);
  logic    lvl_now;
  logic    lvl_q;
  logic    edge_seen;
  logic    expire;
  logic    fire;
  strobe_t strobe_d;
  strobe_t strobe_q;

  isolink_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (din),
    .q     (lvl_now)
  );

  isolink_refresh_timer #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_ok  (pwr_ok),
    .restart (fire),
    .expire  (expire)
  );

  assign edge_seen = lvl_now ^ lvl_q;
  // An edge and an expiry both send the present level, so they merge.
  assign fire = pwr_ok & (edge_seen | expire);

  always_comb begin
    strobe_d.set = fire &  lvl_now;
    strobe_d.clr = fire & ~lvl_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= 1'b0;
      strobe_q <= '0;
    end else begin
      lvl_q    <= lvl_now;
      strobe_q <= strobe_d;
    end
  end

  assign strobe = strobe_q;
endmodule

// File: rtl/isolink_tx_encoder.sv
`timescale 1ns/1ps
module isolink_tx_encoder
  import isolink_pkg::*;
#(
  parameter int N_CH           = 5,
  parameter int SYNC_STAGES    = 2,
  parameter int REFRESH_CYCLES = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_ok,
  input  logic [N_CH-1:0] din,
  output logic [N_CH-1:0] set_pulse,
  output logic [N_CH-1:0] clr_pulse
);
  strobe_t strobes [N_CH];

  generate
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      isolink_chan #(
        .SYNC_STAGES    (SYNC_STAGES),
        .REFRESH_CYCLES (REFRESH_CYCLES)
      ) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok),
        .din    (din[ch]),
        .strobe (strobes[ch])
      );
      assign set_pulse[ch] = strobes[ch].set;
      assign clr_pulse[ch] = strobes[ch].clr;
    end
  endgenerate
endmodule

// File: rtl/isolink_tx_checker.sv
`timescale 1ns/1ps
module isolink_tx_checker #(
  parameter int N_CH        = 5,
  parameter int SYNC_STAGES = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwr_ok,
  input logic [N_CH-1:0] din,
  input logic [N_CH-1:0] set_pulse,
  input logic [N_CH-1:0] clr_pulse
);
  localparam int LAT = SYNC_STAGES + 1;

  logic [N_CH-1:0] hist_q [LAT+1];
  logic            pwr_d1;
  logic [N_CH-1:0] rise_exp;
  logic [N_CH-1:0] fall_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= LAT; i++) hist_q[i] <= '0;
      pwr_d1 <= 1'b0;
    end else begin
      hist_q[0] <= din;
      for (int i = 1; i <= LAT; i++) hist_q[i] <= hist_q[i-1];
      pwr_d1 <= pwr_ok;
    end
  end

  assign rise_exp = hist_q[LAT-1] & ~hist_q[LAT] & {N_CH{pwr_d1}};
  assign fall_exp = ~hist_q[LAT-1] & hist_q[LAT] & {N_CH{pwr_d1}};

  // R1
  rise_gives_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_exp & ~set_pulse) == '0));

  // R2
  fall_gives_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_exp & ~clr_pulse) == '0));

  // R3
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_pulse & clr_pulse) == '0));

  // R3
  single_cycle_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_pulse) |=> ((set_pulse & $past(set_pulse)) == '0));

  // R8
  gated_when_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_ok) |=> ((set_pulse | clr_pulse) == '0));

  // R9
  powerup_refresh_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ok) |=> ((set_pulse | clr_pulse) == {N_CH{1'b1}}));
endmodule

bind isolink_tx_encoder isolink_tx_checker #(
  .N_CH        (N_CH),
  .SYNC_STAGES (SYNC_STAGES)
) u_isolink_tx_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_ok    (pwr_ok),
  .din       (din),
  .set_pulse (set_pulse),
  .clr_pulse (clr_pulse)
);

// File: tb/test_isolink_tx_encoder.sv
`timescale 1ns/1ps
module test_isolink_tx_encoder;
  localparam int N   = 5;
  localparam int REF = 200;

  logic         clk;
  logic         rst_n;
  logic         pwr_ok;
  logic [N-1:0] din;
  logic [N-1:0] set_pulse;
  logic [N-1:0] clr_pulse;

  int checks;
  int errors;

  isolink_tx_encoder #(.N_CH(N), .SYNC_STAGES(2), .REFRESH_CYCLES(REF)) i_isolink_tx_encoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ok    (pwr_ok),
    .din       (din),
    .set_pulse (set_pulse),
    .clr_pulse (clr_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic [N-1:0] es, input logic [N-1:0] ec);
    checks++;
    if (set_pulse !== es || clr_pulse !== ec) begin
      errors++;
      $display("FAIL %s: set=%b clr=%b expected set=%b clr=%b", req, set_pulse, clr_pulse, es, ec);
    end
  endtask

  task automatic quiet(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      step();
      expect_out(req, '0, '0);
    end
  endtask

  // Drops power, sets the inputs, restores power; returns right after the
  // power-up refresh has been observed (time reference E).
  task automatic power_cycle(input logic [N-1:0] v);
    @(negedge clk);
    pwr_ok = 1'b0;
    din    = v;
    quiet("R8", 6);
    @(negedge clk);
    pwr_ok = 1'b1;
    step();
    expect_out("R9", v, ~v);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwr_ok = 1'b0; din = '0;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R10", '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_static_refresh();
    power_cycle(5'b10110);
    quiet("R4", REF - 1);
    step();
    expect_out("R4", 5'b10110, 5'b01001);
  endtask

  task automatic t_edges();
    power_cycle(5'b10110);
    @(negedge clk); din = 5'b10111;
    quiet("R1", 2);
    step(); expect_out("R1", 5'b00001, '0);        // E+3
    quiet("R7", REF - 4);
    step(); expect_out("R7", 5'b10110, 5'b01000);  // E+200, ch0 restarted
    quiet("R5", 2);
    step(); expect_out("R5", 5'b00001, '0);        // E+203
    @(negedge clk); din = 5'b10110;
    quiet("R2", 2);
    step(); expect_out("R2", '0, 5'b00001);
  endtask

  task automatic t_coincide();
    power_cycle(5'b00010);
    quiet("R6", REF - 3);                          // up to E+197
    @(negedge clk); din = 5'b00000;
    quiet("R6", 2);
    step(); expect_out("R6", '0, 5'b11111);        // E+200 single clear on ch1
    quiet("R6", REF - 1);
    step(); expect_out("R6", '0, 5'b11111);
  endtask

  task automatic t_power_gate();
    power_cycle(5'b01100);
    @(negedge clk); pwr_ok = 1'b0;
    @(negedge clk); din = 5'b10011;
    quiet("R8", REF + 100);
    @(negedge clk); pwr_ok = 1'b1;
    step(); expect_out("R9", 5'b10011, 5'b01100);
  endtask

  task automatic t_min_pulse();
    power_cycle(5'b00000);
    @(negedge clk); din = 5'b10000;
    quiet("R11", 2);
    step(); expect_out("R11", 5'b10000, '0);       // E+3
    quiet("R11", 17);                              // E+20
    @(negedge clk); din = 5'b00000;
    quiet("R11", 2);
    step(); expect_out("R11", '0, 5'b10000);       // E+23
  endtask

  task automatic t_toggle();
    power_cycle(5'b00000);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); din[2] = ~din[2];
      step();
      if (i >= 2) begin
        if (((i - 2) % 2) == 0) expect_out("R3", 5'b00100, '0);
        else                    expect_out("R3", '0, 5'b00100);
      end
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_static_refresh();
    t_edges();
    t_coincide();
    t_power_gate();
    t_min_pulse();
    t_toggle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule